// File: doc/BRIEF.md
# Dyadic Operand Rendezvous Unit

This block pairs the two operands of a two-input dataflow instruction. Every incoming token carries a tag, a data value and a one-bit port flag that says whether it is the left or the right operand. The tag is a frame base and an instruction address, and together they name one computation instance. The instruction address selects an entry in a small, writable instruction table. That entry gives an opcode, a slot offset and up to two destinations, each with an address displacement and a port flag. The operand slot is the frame base plus the offset.

Each slot has a presence bit. When the first operand of a pair arrives, it is parked in its slot. When the partner arrives, the slot is emptied and a fire packet goes to the arithmetic stage, with the left and right operands placed by their port flags. An instruction marked single-input fires at once and never touches the frame. When the arithmetic stage returns a result, the unit turns it into one tagged token for each enabled destination. These tokens keep the frame base and advance the instruction address by that destination's displacement.

Top module: `mtc_unit`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `fire_valid`, `proto_err` and every `dst_valid` bit are 0. All slots start empty, so the first operand sent to any slot after reset is parked and nothing fires.
- R2: A token for a two-input instruction whose slot is empty is stored in the slot. No fire packet and no error follow it.
- R3: A token that finds its slot full, with its port flag (0 = left, 1 = right) opposite to the stored one, produces a fire packet one cycle later. `fire_op` is the table opcode, and `fire_fp` and `fire_ip` are the token's tag. The slot is left empty, so the next token sent to it is stored again.
- R4: On firing, the operand with port flag 0 appears on `fire_left` and the operand with port flag 1 appears on `fire_right`, whichever of them arrived first.
- R5: The slot address is (frame base + table offset) modulo 2^ADDR_W. Tokens with equal instruction address but different frame bases use different slots. Different tags whose sums are equal, including sums that wrap, share a slot.
- R6: An entry with the single-input bit set fires one cycle after its token, with `fire_left` = token data and `fire_right` = 0. It leaves the frame store unchanged.
- R7: A token that finds its slot full with the same port flag as the stored operand pulses `proto_err` one cycle later. It does not fire, and the stored operand is kept.
- R8: One cycle after `res_valid`, `dst_valid[k]` equals the enable bit k of the entry at `res_ip`. For each enabled k, `dst_ip[k]` = (`res_ip` + displacement k) modulo 2^IP_W and `dst_port[k]` is the port flag of destination k. `dst_fp` and `dst_data` repeat `res_fp` and `res_data`.
- R9: Tokens may arrive on consecutive cycles. Each one sees the slot state left by the token before it, and each fire or error is a single-cycle pulse.
- R10: `prog_we` writes all fields of the entry at `prog_addr` at the clock edge, and the next token or result uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Instruction table write strobe |
| prog_addr | input | IP_W | Entry to write |
| prog_op | input | OP_W | Opcode field |
| prog_monadic | input | 1 | 1 = single-input instruction |
| prog_off | input | OFF_W | Slot offset from the frame base |
| prog_dst_en | input | NDEST | Destination enable bits |
| prog_disp | input | NDEST x IP_W | Destination address displacements |
| prog_dst_port | input | NDEST | Destination port flags (0 left, 1 right) |
| tok_valid | input | 1 | Incoming token strobe |
| tok_fp | input | ADDR_W | Token frame base |
| tok_ip | input | IP_W | Token instruction address |
| tok_data | input | DATA_W | Token value |
| tok_port | input | 1 | Token port flag (0 left, 1 right) |
| fire_valid | output | 1 | Fire packet strobe |
| fire_op | output | OP_W | Opcode to execute |
| fire_fp | output | ADDR_W | Frame base of the firing instance |
| fire_ip | output | IP_W | Instruction address of the firing instance |
| fire_left | output | DATA_W | Left operand |
| fire_right | output | DATA_W | Right operand |
| proto_err | output | 1 | Same-port collision pulse |
| res_valid | input | 1 | Result strobe from the arithmetic stage |
| res_fp | input | ADDR_W | Result frame base |
| res_ip | input | IP_W | Instruction address that produced the result |
| res_data | input | DATA_W | Result value |
| dst_valid | output | NDEST | Destination token strobes |
| dst_fp | output | ADDR_W | Frame base of the destination tokens |
| dst_ip | output | NDEST x IP_W | Destination instruction addresses |
| dst_data | output | DATA_W | Destination token value |
| dst_port | output | NDEST | Destination port flags |

## Verification
The case hardest to reach from the ports is a slot whose state was set by one tag and is then read by another. Examples are a full slot being hit by a same-port token, or a frame base near the top of the store wrapping onto slot 0. The stimulus gets there in two ways. It parks an operand and then sends a second token with the same port to that exact slot. It also programs two entries with different offsets and sends them frame bases whose sums alias. In both cases the bench then sends the opposite-port partner, which proves through `fire_left` and `fire_right` that the parked value survived. Single-input tokens and back-to-back pairs are placed between these steps, so that any stray write to the frame store would show up in a later fire packet.

// File: rtl/mtc_pkg.sv
// Shared definitions for the operand rendezvous unit.
// Assumes: port flag 0 means left operand, 1 means right operand.
package mtc_pkg;
    typedef enum logic {
        PORT_LEFT  = 1'b0,
        PORT_RIGHT = 1'b1
    } port_e;
endpackage

// File: rtl/mtc_instr_table.sv
// Instruction table: one entry per instruction address, written through a
// single program port and read combinationally by the token side and the
// result side at the same time.
// Assumes: writes and reads in the same cycle see the old contents.
module mtc_instr_table #(
    parameter int IP_W  = 5,
    parameter int OP_W  = 4,
    parameter int OFF_W = 4,
    parameter int NDEST = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IP_W-1:0]            wr_addr,
    input  logic [OP_W-1:0]            wr_op,
    input  logic                       wr_mon,
    input  logic [OFF_W-1:0]           wr_off,
    input  logic [NDEST-1:0]           wr_en_dst,
    input  logic [NDEST-1:0][IP_W-1:0] wr_disp,
    input  logic [NDEST-1:0]           wr_port,
    input  logic [IP_W-1:0]            ta_addr,
    output logic [OP_W-1:0]            ta_op,
    output logic                       ta_mon,
    output logic [OFF_W-1:0]           ta_off,
    input  logic [IP_W-1:0]            ra_addr,
    output logic [NDEST-1:0]           ra_en,
    output logic [NDEST-1:0][IP_W-1:0] ra_disp,
    output logic [NDEST-1:0]           ra_port
);
    localparam int DEPTH = 1 << IP_W;

    logic [DEPTH-1:0][OP_W-1:0]            op_q;
    logic [DEPTH-1:0]                      mon_q;
    logic [DEPTH-1:0][OFF_W-1:0]           off_q;
    logic [DEPTH-1:0][NDEST-1:0]           en_q;
    logic [DEPTH-1:0][NDEST-1:0][IP_W-1:0] disp_q;
    logic [DEPTH-1:0][NDEST-1:0]           port_q;

    // Purpose: clear the table on reset, else write one entry on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            mon_q  <= '0;
            off_q  <= '0;
            en_q   <= '0;
            disp_q <= '0;
            port_q <= '0;
        end else if (wr_en) begin
            op_q[wr_addr]   <= wr_op;
            mon_q[wr_addr]  <= wr_mon;
            off_q[wr_addr]  <= wr_off;
            en_q[wr_addr]   <= wr_en_dst;
            disp_q[wr_addr] <= wr_disp;
            port_q[wr_addr] <= wr_port;
        end
    end

    // Purpose: token-side read of opcode, single-input bit and offset.
    always_comb begin
        ta_op  = op_q[ta_addr];
        ta_mon = mon_q[ta_addr];
        ta_off = off_q[ta_addr];
    end

    // Purpose: result-side read of the destination list.
    always_comb begin
        ra_en   = en_q[ra_addr];
        ra_disp = disp_q[ra_addr];
        ra_port = port_q[ra_addr];
    end
endmodule

// File: rtl/mtc_frame_store.sv
// Frame store: one operand slot per address, each with a presence bit and
// the port flag of the parked operand. One read-modify-write per cycle:
// an empty slot takes the operand; a full slot with the opposite port is
// emptied; a full slot with the same port is left as it is.
// Assumes: the caller decides firing from the combinational slot view.
module mtc_frame_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              acc_port,
    output logic              slot_full,
    output logic [DATA_W-1:0] slot_data,
    output logic              slot_port
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]             full_q;
    logic [DEPTH-1:0]             port_q;
    logic [DEPTH-1:0][DATA_W-1:0] val_q;

    // Purpose: combinational view of the addressed slot.
    always_comb begin
        slot_full = full_q[acc_addr];
        slot_data = val_q[acc_addr];
        slot_port = port_q[acc_addr];
    end

    // Purpose: presence bits; set on park, cleared on a matching partner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else if (acc_en) begin
            if (!full_q[acc_addr]) begin
                full_q[acc_addr] <= 1'b1;
            end else if (port_q[acc_addr] != acc_port) begin
                full_q[acc_addr] <= 1'b0;
            end
        end
    end

    // Purpose: slot payload; only meaningful while its presence bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else if (acc_en && !full_q[acc_addr]) begin
            port_q[acc_addr] <= acc_port;
        end
    end

    // Purpose: data array, written when an operand is parked (no reset needed).
    always_ff @(posedge clk) begin
        if (acc_en && !full_q[acc_addr]) begin
            val_q[acc_addr] <= acc_data;
        end
    end
endmodule

// File: rtl/mtc_dest_gen.sv
// Destination generator: turns one result into up to NDEST tagged tokens,
// each with the same frame base and an instruction address advanced by its
// displacement. Registered, one cycle of latency.
// Assumes: the destination list is read from the table in the result cycle.
module mtc_dest_gen #(
    parameter int ADDR_W = 6,
    parameter int IP_W   = 5,
    parameter int DATA_W = 16,
    parameter int NDEST  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       res_valid,
    input  logic [ADDR_W-1:0]          res_fp,
    input  logic [IP_W-1:0]            res_ip,
    input  logic [DATA_W-1:0]          res_data,
    input  logic [NDEST-1:0]           tbl_en,
    input  logic [NDEST-1:0][IP_W-1:0] tbl_disp,
    input  logic [NDEST-1:0]           tbl_port,
    output logic [NDEST-1:0]           dst_valid,
    output logic [ADDR_W-1:0]          dst_fp,
    output logic [NDEST-1:0][IP_W-1:0] dst_ip,
    output logic [DATA_W-1:0]          dst_data,
    output logic [NDEST-1:0]           dst_port
);
    // Purpose: shared tag and value of all destination tokens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_fp   <= '0;
            dst_data <= '0;
        end else if (res_valid) begin
            dst_fp   <= res_fp;
            dst_data <= res_data;
        end
    end

    for (genvar k = 0; k < NDEST; k++) begin : g_dst
        // Purpose: per-destination strobe, address and port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_valid[k] <= 1'b0;
                dst_ip[k]    <= '0;
                dst_port[k]  <= 1'b0;
            end else begin
                dst_valid[k] <= res_valid && tbl_en[k];
                if (res_valid) begin
                    dst_ip[k]   <= res_ip + tbl_disp[k];
                    dst_port[k] <= tbl_port[k];
                end
            end
        end
    end
endmodule

// File: rtl/mtc_unit.sv
// Operand rendezvous unit top. A token looks up its instruction, addresses
// slot (frame base + offset), and either parks, fires, or flags a same-port
// collision. Single-input instructions fire without touching the frame.
// Results are expanded into destination tokens by mtc_dest_gen.
// Assumes: at most one token and one result per cycle, no back-pressure.
module mtc_unit #(
    parameter int ADDR_W = 6,
    parameter int IP_W   = 5,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int OFF_W  = 4,
    parameter int NDEST  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prog_we,
    input  logic [IP_W-1:0]            prog_addr,
    input  logic [OP_W-1:0]            prog_op,
    input  logic                       prog_monadic,
    input  logic [OFF_W-1:0]           prog_off,
    input  logic [NDEST-1:0]           prog_dst_en,
    input  logic [NDEST-1:0][IP_W-1:0] prog_disp,
    input  logic [NDEST-1:0]           prog_dst_port,
    input  logic                       tok_valid,
    input  logic [ADDR_W-1:0]          tok_fp,
    input  logic [IP_W-1:0]            tok_ip,
    input  logic [DATA_W-1:0]          tok_data,
    input  logic                       tok_port,
    output logic                       fire_valid,
    output logic [OP_W-1:0]            fire_op,
    output logic [ADDR_W-1:0]          fire_fp,
    output logic [IP_W-1:0]            fire_ip,
    output logic [DATA_W-1:0]          fire_left,
    output logic [DATA_W-1:0]          fire_right,
    output logic                       proto_err,
    input  logic                       res_valid,
    input  logic [ADDR_W-1:0]          res_fp,
    input  logic [IP_W-1:0]            res_ip,
    input  logic [DATA_W-1:0]          res_data,
    output logic [NDEST-1:0]           dst_valid,
    output logic [ADDR_W-1:0]          dst_fp,
    output logic [NDEST-1:0][IP_W-1:0] dst_ip,
    output logic [DATA_W-1:0]          dst_data,
    output logic [NDEST-1:0]           dst_port
);
    import mtc_pkg::*;

    logic [OP_W-1:0]            t_op;
    logic                       t_mon;
    logic [OFF_W-1:0]           t_off;
    logic [NDEST-1:0]           r_en;
    logic [NDEST-1:0][IP_W-1:0] r_disp;
    logic [NDEST-1:0]           r_port;
    logic                       acc_en;
    logic [ADDR_W-1:0]          slot_addr;
    logic                       slot_full;
    logic [DATA_W-1:0]          slot_data;
    logic                       slot_port;
    logic                       fire_d;
    logic                       err_d;
    logic [DATA_W-1:0]          left_d;
    logic [DATA_W-1:0]          right_d;

    mtc_instr_table #(
        .IP_W(IP_W), .OP_W(OP_W), .OFF_W(OFF_W), .NDEST(NDEST)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prog_we),
        .wr_addr   (prog_addr),
        .wr_op     (prog_op),
        .wr_mon    (prog_monadic),
        .wr_off    (prog_off),
        .wr_en_dst (prog_dst_en),
        .wr_disp   (prog_disp),
        .wr_port   (prog_dst_port),
        .ta_addr   (tok_ip),
        .ta_op     (t_op),
        .ta_mon    (t_mon),
        .ta_off    (t_off),
        .ra_addr   (res_ip),
        .ra_en     (r_en),
        .ra_disp   (r_disp),
        .ra_port   (r_port)
    );

    // Purpose: slot address and frame access enable for two-input tokens.
    always_comb begin
        slot_addr = tok_fp + ADDR_W'(t_off);
        acc_en    = tok_valid && !t_mon;
    end

    mtc_frame_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_addr  (slot_addr),
        .acc_data  (tok_data),
        .acc_port  (tok_port),
        .slot_full (slot_full),
        .slot_data (slot_data),
        .slot_port (slot_port)
    );

    // Purpose: decide fire / error and place operands by their port flags.
    always_comb begin
        fire_d  = tok_valid && (t_mon || (slot_full && (slot_port != tok_port)));
        err_d   = acc_en && slot_full && (slot_port == tok_port);
        left_d  = tok_data;
        right_d = '0;
        if (!t_mon) begin
            if (port_e'(tok_port) == PORT_LEFT) begin
                left_d  = tok_data;
                right_d = slot_data;
            end else begin
                left_d  = slot_data;
                right_d = tok_data;
            end
        end
    end

    // Purpose: register the fire packet and the collision pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_valid <= 1'b0;
            proto_err  <= 1'b0;
            fire_op    <= '0;
            fire_fp    <= '0;
            fire_ip    <= '0;
            fire_left  <= '0;
            fire_right <= '0;
        end else begin
            fire_valid <= fire_d;
            proto_err  <= err_d;
            if (fire_d) begin
                fire_op    <= t_op;
                fire_fp    <= tok_fp;
                fire_ip    <= tok_ip;
                fire_left  <= left_d;
                fire_right <= right_d;
            end
        end
    end

    mtc_dest_gen #(
        .ADDR_W(ADDR_W), .IP_W(IP_W), .DATA_W(DATA_W), .NDEST(NDEST)
    ) u_dest (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_fp    (res_fp),
        .res_ip    (res_ip),
        .res_data  (res_data),
        .tbl_en    (r_en),
        .tbl_disp  (r_disp),
        .tbl_port  (r_port),
        .dst_valid (dst_valid),
        .dst_fp    (dst_fp),
        .dst_ip    (dst_ip),
        .dst_data  (dst_data),
        .dst_port  (dst_port)
    );
endmodule

// File: rtl/mtc_unit_chk.sv
// Checker for mtc_unit: port-level temporal properties, bound to the top.
// Assumes: synchronous active-low reset held from time zero.
module mtc_unit_chk #(
    parameter int ADDR_W = 6,
    parameter int IP_W   = 5,
    parameter int DATA_W = 16,
    parameter int NDEST  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [ADDR_W-1:0] tok_fp,
    input logic [IP_W-1:0]   tok_ip,
    input logic              fire_valid,
    input logic [ADDR_W-1:0] fire_fp,
    input logic [IP_W-1:0]   fire_ip,
    input logic              proto_err,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_fp,
    input logic [DATA_W-1:0] res_data,
    input logic [NDEST-1:0]  dst_valid,
    input logic [ADDR_W-1:0] dst_fp,
    input logic [DATA_W-1:0] dst_data
);
    // R1: outputs quiet the cycle after reset is sampled low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!fire_valid && !proto_err && (dst_valid == '0)));

    // R3: a fire packet carries the tag of the token one cycle earlier
    assert_fire_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> ($past(tok_valid) && fire_fp == $past(tok_fp)
                        && fire_ip == $past(tok_ip)));

    // R7: a collision never fires
    assert_err_no_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !fire_valid);

    // R7: an error pulse needs a token one cycle earlier
    assert_err_needs_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(tok_valid));

    // R8: destination tokens follow a result and copy its tag and value
    assert_dst_follows_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid != '0) |-> ($past(res_valid) && dst_fp == $past(res_fp)
                               && dst_data == $past(res_data)));

    // R9: with no token, nothing fires or errors in the next cycle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> (!fire_valid && !proto_err));
endmodule

bind mtc_unit mtc_unit_chk #(
    .ADDR_W(ADDR_W), .IP_W(IP_W), .DATA_W(DATA_W), .NDEST(NDEST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_fp     (tok_fp),
    .tok_ip     (tok_ip),
    .fire_valid (fire_valid),
    .fire_fp    (fire_fp),
    .fire_ip    (fire_ip),
    .proto_err  (proto_err),
    .res_valid  (res_valid),
    .res_fp     (res_fp),
    .res_data   (res_data),
    .dst_valid  (dst_valid),
    .dst_fp     (dst_fp),
    .dst_data   (dst_data)
);

// File: tb/mtc_unit_tb.sv
// Directed bench for mtc_unit: one task per scenario, each checking itself.
module mtc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int IP_W   = 5;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int OFF_W  = 4;
    localparam int NDEST  = 2;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       prog_we = 1'b0;
    logic [IP_W-1:0]            prog_addr = '0;
    logic [OP_W-1:0]            prog_op = '0;
    logic                       prog_monadic = 1'b0;
    logic [OFF_W-1:0]           prog_off = '0;
    logic [NDEST-1:0]           prog_dst_en = '0;
    logic [NDEST-1:0][IP_W-1:0] prog_disp = '0;
    logic [NDEST-1:0]           prog_dst_port = '0;
    logic                       tok_valid = 1'b0;
    logic [ADDR_W-1:0]          tok_fp = '0;
    logic [IP_W-1:0]            tok_ip = '0;
    logic [DATA_W-1:0]          tok_data = '0;
    logic                       tok_port = 1'b0;
    logic                       fire_valid;
    logic [OP_W-1:0]            fire_op;
    logic [ADDR_W-1:0]          fire_fp;
    logic [IP_W-1:0]            fire_ip;
    logic [DATA_W-1:0]          fire_left;
    logic [DATA_W-1:0]          fire_right;
    logic                       proto_err;
    logic                       res_valid = 1'b0;
    logic [ADDR_W-1:0]          res_fp = '0;
    logic [IP_W-1:0]            res_ip = '0;
    logic [DATA_W-1:0]          res_data = '0;
    logic [NDEST-1:0]           dst_valid;
    logic [ADDR_W-1:0]          dst_fp;
    logic [NDEST-1:0][IP_W-1:0] dst_ip;
    logic [DATA_W-1:0]          dst_data;
    logic [NDEST-1:0]           dst_port;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtc_unit #(
        .ADDR_W(ADDR_W), .IP_W(IP_W), .DATA_W(DATA_W),
        .OP_W(OP_W), .OFF_W(OFF_W), .NDEST(NDEST)
    ) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Writes one table entry; usable from the next cycle.
    task automatic prog(input int ip, input int op, input bit mon, input int off,
                        input logic [1:0] en, input int d0, input int d1,
                        input logic [1:0] pt);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = IP_W'(ip); prog_op = OP_W'(op);
        prog_monadic = mon; prog_off = OFF_W'(off); prog_dst_en = en;
        prog_disp[0] = IP_W'(d0); prog_disp[1] = IP_W'(d1); prog_dst_port = pt;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // Sends one token; on return the outputs reflect it.
    task automatic tok(input int fp, input int ip, input int data, input bit port);
        @(negedge clk);
        tok_valid = 1'b1; tok_fp = ADDR_W'(fp); tok_ip = IP_W'(ip);
        tok_data = DATA_W'(data); tok_port = port;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic expect_fire(input string req, input int op, input int fp, input int ip,
                               input int l, input int r);
        check({req, " fire_valid"}, 32'(fire_valid), 32'd1);
        check({req, " proto_err"}, 32'(proto_err), 32'd0);
        check({req, " fire_op"}, 32'(fire_op), 32'(op));
        check({req, " fire_fp"}, 32'(fire_fp), 32'(fp));
        check({req, " fire_ip"}, 32'(fire_ip), 32'(ip));
        check({req, " fire_left"}, 32'(fire_left), 32'(l));
        check({req, " fire_right"}, 32'(fire_right), 32'(r));
    endtask

    task automatic expect_quiet(input string req);
        check({req, " fire_valid"}, 32'(fire_valid), 32'd0);
        check({req, " proto_err"}, 32'(proto_err), 32'd0);
    endtask

    // R1: outputs idle after reset, every slot empty.
    task automatic t_reset();
        check("R1 fire_valid", 32'(fire_valid), 32'd0);
        check("R1 proto_err", 32'(proto_err), 32'd0);
        check("R1 dst_valid", 32'(dst_valid), 32'd0);
    endtask

    // R10: table contents used by all later scenarios.
    task automatic t_program();
        prog(1, 3, 1'b0, 2, 2'b11, 1, 2, 2'b10);
        prog(2, 5, 1'b1, 0, 2'b01, 3, 0, 2'b01);
        prog(3, 7, 1'b0, 0, 2'b10, 0, 30, 2'b00);
        prog(4, 9, 1'b0, 1, 2'b00, 0, 0, 2'b00);
    endtask

    // R2, R3, R4: park, pair, empty, both arrival orders.
    task automatic t_pair();
        tok(10, 1, 16'h1111, 1'b0);
        expect_quiet("R1 R2 first park after reset");
        tok(10, 1, 16'h2222, 1'b1);
        expect_fire("R3 R4 left first", 3, 10, 1, 16'h1111, 16'h2222);
        tok(10, 1, 16'h3333, 1'b0);
        expect_quiet("R3 slot emptied then parks again");
        tok(10, 1, 16'h4444, 1'b1);
        expect_fire("R3 re-pair", 3, 10, 1, 16'h3333, 16'h4444);
        tok(20, 1, 16'h0A0A, 1'b1);
        expect_quiet("R2 right parks");
        tok(20, 1, 16'h0B0B, 1'b0);
        expect_fire("R4 right first", 3, 20, 1, 16'h0B0B, 16'h0A0A);
    endtask

    // R5: frame separation and wrapping slot address.
    task automatic t_addr();
        tok(30, 1, 16'h0030, 1'b0);
        expect_quiet("R5 frame 30 parks");
        tok(31, 1, 16'h0031, 1'b1);
        expect_quiet("R5 frame 31 separate slot");
        tok(30, 1, 16'h0130, 1'b1);
        expect_fire("R5 frame 30 pairs", 3, 30, 1, 16'h0030, 16'h0130);
        tok(31, 1, 16'h0131, 1'b0);
        expect_fire("R5 frame 31 pairs", 3, 31, 1, 16'h0131, 16'h0031);
        tok(63, 4, 16'hAAAA, 1'b0);
        expect_quiet("R5 wrap parks in slot 0");
        tok(0, 3, 16'hBBBB, 1'b1);
        expect_fire("R5 aliased slot pairs", 7, 0, 3, 16'hAAAA, 16'hBBBB);
    endtask

    // R6: single-input fires at once, frame untouched.
    task automatic t_monadic();
        tok(4, 4, 16'h0044, 1'b0);
        expect_quiet("R6 park in slot 5");
        tok(5, 2, 16'h0055, 1'b1);
        expect_fire("R6 monadic", 5, 5, 2, 16'h0055, 0);
        tok(4, 4, 16'h0077, 1'b1);
        expect_fire("R6 slot unchanged", 9, 4, 4, 16'h0044, 16'h0077);
    endtask

    // R7: same-port collision flags, keeps the parked operand.
    task automatic t_collide();
        tok(40, 1, 16'h1234, 1'b0);
        expect_quiet("R7 park");
        tok(40, 1, 16'h9999, 1'b0);
        check("R7 proto_err", 32'(proto_err), 32'd1);
        check("R7 no fire", 32'(fire_valid), 32'd0);
        tok(40, 1, 16'h4321, 1'b1);
        expect_fire("R7 original kept", 3, 40, 1, 16'h1234, 16'h4321);
    endtask

    // R9: three tokens on consecutive cycles.
    task automatic t_b2b();
        @(negedge clk);
        tok_valid = 1'b1; tok_fp = 6'd50; tok_ip = 5'd1; tok_data = 16'd1; tok_port = 1'b0;
        @(negedge clk);
        expect_quiet("R9 b2b first");
        tok_fp = 6'd50; tok_ip = 5'd1; tok_data = 16'd2; tok_port = 1'b1;
        @(negedge clk);
        expect_fire("R9 b2b pair", 3, 50, 1, 1, 2);
        tok_fp = 6'd0; tok_ip = 5'd2; tok_data = 16'd3; tok_port = 1'b0;
        @(negedge clk);
        tok_valid = 1'b0;
        expect_fire("R9 b2b monadic", 5, 0, 2, 3, 0);
        @(negedge clk);
        expect_quiet("R9 single-cycle pulse");
    endtask

    task automatic res(input int fp, input int ip, input int data);
        @(negedge clk);
        res_valid = 1'b1; res_fp = ADDR_W'(fp); res_ip = IP_W'(ip); res_data = DATA_W'(data);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // R8: destination token generation.
    task automatic t_result();
        res(9, 1, 16'hBEEF);
        check("R8 valid both", 32'(dst_valid), 32'b11);
        check("R8 fp", 32'(dst_fp), 32'd9);
        check("R8 data", 32'(dst_data), 32'hBEEF);
        check("R8 ip0", 32'(dst_ip[0]), 32'd2);
        check("R8 ip1", 32'(dst_ip[1]), 32'd3);
        check("R8 ports", 32'(dst_port), 32'b10);
        res(12, 3, 16'h0101);
        check("R8 only dst1", 32'(dst_valid), 32'b10);
        check("R8 wrapped ip1", 32'(dst_ip[1]), 32'd1);
        check("R8 port1 left", 32'(dst_port[1]), 32'd0);
        res(12, 2, 16'h0202);
        check("R8 only dst0", 32'(dst_valid), 32'b01);
        check("R8 ip0 disp3", 32'(dst_ip[0]), 32'd5);
        check("R8 port0 right", 32'(dst_port[0]), 32'd1);
        res(12, 4, 16'h0303);
        check("R8 none enabled", 32'(dst_valid), 32'b00);
        @(negedge clk);
        check("R8 pulse ends", 32'(dst_valid), 32'b00);
    endtask

    // R10: rewriting an entry takes effect on the next token.
    task automatic t_reprog();
        prog(4, 12, 1'b1, 0, 2'b00, 0, 0, 2'b00);
        tok(7, 4, 16'h0C0C, 1'b1);
        expect_fire("R10 rewritten entry", 12, 7, 4, 16'h0C0C, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_program();
        t_pair();
        t_addr();
        t_monadic();
        t_collide();
        t_b2b();
        t_result();
        t_reprog();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule